// File: doc/BRIEF.md
# Bit-Plane Display Refresh Scanner

This block refreshes a four-chip LED display controller array from a greyscale frame store. The store holds three bit planes. Each plane has sixteen pixel rows, and each row is two bytes wide. On each refresh pass the scanner reads every byte of the current plane and issues one register write per byte. Each write drives a short row address, the data byte, a write enable and exactly one chip-select strobe. After a pass the scanner goes idle for a dwell time set by the plane it has just sent, then moves on to the next plane. The unequal dwell times weight the planes against each other, and the display shows the result as grey levels.

Each pixel row is split across the four chips. The top half of the display and the bottom half use different chip pairs, and the two bytes of a row go to different chips within the pair. A host port fills the frame store. It may be used at any time, including during a pass. When the scanner needs the single store port, the host is stalled.

Top module: `plane_scan_refresh`

## Requirements
- R1: After reset, `busy_o`, `wr_en_o`, `chip_sel_o` and `sop_o` are all 0 and `host_ready_o` is 1. The first idle period lasts (20+1)*PRESCALE cycles. The first write then follows.
- R2: A pass sends its 32 bytes in this order: rows ascending from 0 to 15, byte 0 before byte 1 within a row. The first pass after reset sends plane 0.
- R3: Chip-select bits are active high. For rows 0 to 7, byte 0 strobes bit 3 and byte 1 strobes bit 2. For rows 8 to 15, byte 0 strobes bit 0 and byte 1 strobes bit 1. `row_addr_o` carries the row number modulo 8, so bit 3 is always 0.
- R4: The data of each write is the stored byte at host index plane*32 + row*2 + byte.
- R5: During a write, `wr_en_o` and exactly one chip-select bit are high together for STROBE_CYCLES cycles. `row_addr_o` and `data_o` hold their value from at least one cycle before the strobe until at least one cycle after it.
- R6: After a pass of plane p, the idle period lasts (C[p]+1)*PRESCALE cycles, with C = {3, 4, 22} for planes 0, 1 and 2.
- R7: The plane number advances after every pass and wraps from 2 back to 0.
- R8: `busy_o` is high for exactly 32*(STROBE_CYCLES+3) cycles per pass and is low during every idle period. No chip select is active while `busy_o` is low.
- R9: `sop_o` is a one-cycle pulse in the first cycle of each pass, which is the cycle in which `busy_o` rises.
- R10: A host write (`host_we_i` high while `host_ready_o` is high at a clock edge) stores the byte at its index. `host_ready_o` is low only in the cycles in which the scanner reads the store, and those cycles occur only while busy. A byte written during a pass is sent on the next pass of its plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host store write request |
| host_addr_i | input | 7 | Host store index (plane*32 + row*2 + byte) |
| host_wdata_i | input | 8 | Host store write byte |
| host_ready_o | output | 1 | Host write accepted this cycle when high |
| row_addr_o | output | 4 | Row address bus to the chips |
| data_o | output | 8 | Data bus to the chips |
| wr_en_o | output | 1 | Write enable, high during a strobe |
| chip_sel_o | output | 4 | One-hot chip-select strobe |
| busy_o | output | 1 | High while a pass is being sent |
| sop_o | output | 1 | Start-of-pass pulse |

## Verification
The bench targets the row-half boundary between rows 7 and 8. A design with the wrong address modulo or the wrong chip pairing would strobe the wrong chip or drive an address of 8 or more there. It measures every idle period, including the special first one after reset. An off-by-one compare, a mixed-up plane index or a missing wrap would lengthen or shorten those gaps by whole prescaler periods. It also writes into the store during a pass, and then resets the block mid-pass. A broken arbiter would drop or corrupt the host byte. A broken reset would resume the old pass instead of restarting at plane 0 after the long first idle period.

// File: rtl/plane_scan_pkg.sv
package plane_scan_pkg;

    typedef enum logic [2:0] {
        ST_DWELL  = 3'd0,
        ST_FETCH  = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } scan_state_e;

    // upper: row lies in the lower display half (rows 8..15); bsel: byte index
    function automatic logic [3:0] route_chip(input logic upper, input logic bsel);
        logic [3:0] sel;
        case ({upper, bsel})
            2'b00:   sel = 4'b1000;
            2'b01:   sel = 4'b0100;
            2'b10:   sel = 4'b0001;
            default: sel = 4'b0010;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/plane_scan_fbuf.sv
module plane_scan_fbuf #(
    parameter int DEPTH  = 96,
    parameter int AW     = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              host_we_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ready_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    // single port: a scanner read wins the cycle, the host waits
    assign host_ready_o = !rd_en_i;

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) rd_d = mem_q[rd_addr_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rd_en_i && host_we_i && (host_addr_i < AW'(DEPTH)))
            mem_q[host_addr_i] <= host_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/plane_scan_dwell.sv
module plane_scan_dwell #(
    parameter int PRESCALE = 64,
    parameter int CMP_W    = 8,
    localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CMP_W-1:0] cmp_i,
    output logic             done_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CMP_W-1:0] tick;
    } dwell_t;

    dwell_t r_d, r_q;
    logic   pre_wrap;

    always_comb begin
        pre_wrap = (r_q.pre == PRE_W'(PRESCALE - 1));
        done_o   = run_i && pre_wrap && (r_q.tick == cmp_i);
        r_d      = r_q;
        if (!run_i || done_o) begin
            r_d = '0;
        end else if (pre_wrap) begin
            r_d.pre  = '0;
            r_d.tick = r_q.tick + 1'b1;
        end else begin
            r_d.pre = r_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end
endmodule

// File: rtl/plane_scan_refresh.sv
module plane_scan_refresh
    import plane_scan_pkg::*;
#(
    parameter int          NUM_PLANES    = 3,
    parameter int          NUM_ROWS      = 16,
    parameter int          DATA_W        = 8,
    parameter int          BUS_AW        = 4,
    parameter int          STROBE_CYCLES = 2,
    parameter int          PRESCALE      = 64,
    parameter int          CMP_W         = 8,
    parameter int          FIRST_CMP     = 20,
    parameter int unsigned PLANE_CMP [NUM_PLANES] = '{3, 4, 22},
    localparam int ROW_BYTES    = 2,
    localparam int PLANE_STRIDE = NUM_ROWS * ROW_BYTES,
    localparam int FB_DEPTH     = NUM_PLANES * PLANE_STRIDE,
    localparam int FB_AW        = $clog2(FB_DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_we_i,
    input  logic [FB_AW-1:0]  host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              host_ready_o,
    output logic [BUS_AW-1:0] row_addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              wr_en_o,
    output logic [3:0]        chip_sel_o,
    output logic              busy_o,
    output logic              sop_o
);
    localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1;
    localparam int ROW_W   = $clog2(NUM_ROWS);
    localparam int SC_W    = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;

    typedef struct packed {
        scan_state_e       st;
        logic [PLANE_W-1:0] plane;
        logic [ROW_W-1:0]  row;
        logic              bsel;
        logic [SC_W-1:0]   scnt;
        logic [BUS_AW-1:0] addr;
        logic [3:0]        cs;
        logic              wr;
        logic              sop;
        logic [CMP_W-1:0]  cmp;
    } scan_t;

    scan_t             r_d, r_q;
    logic              rd_en;
    logic [FB_AW-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              dwell_done;

    plane_scan_fbuf #(.DEPTH(FB_DEPTH), .AW(FB_AW), .DATA_W(DATA_W)) u_fbuf (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .rd_en_i      (rd_en),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .host_we_i    (host_we_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_ready_o (host_ready_o)
    );

    plane_scan_dwell #(.PRESCALE(PRESCALE), .CMP_W(CMP_W)) u_dwell (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (r_q.st == ST_DWELL),
        .cmp_i  (r_q.cmp),
        .done_o (dwell_done)
    );

    always_comb begin
        r_d     = r_q;
        r_d.sop = 1'b0;
        rd_en   = (r_q.st == ST_FETCH);
        rd_addr = FB_AW'(PLANE_STRIDE * int'(r_q.plane) + ROW_BYTES * int'(r_q.row)
                         + int'(r_q.bsel));
        case (r_q.st)
            ST_DWELL: begin
                if (dwell_done) begin
                    r_d.st  = ST_FETCH;
                    r_d.sop = 1'b1;
                end
            end
            ST_FETCH: begin
                r_d.st   = ST_SETUP;
                r_d.addr = BUS_AW'(r_q.row[ROW_W-2:0]);
            end
            ST_SETUP: begin
                r_d.st   = ST_STROBE;
                r_d.scnt = '0;
                r_d.cs   = route_chip(r_q.row[ROW_W-1], r_q.bsel);
                r_d.wr   = 1'b1;
            end
            ST_STROBE: begin
                if (r_q.scnt == SC_W'(STROBE_CYCLES - 1)) begin
                    r_d.st = ST_HOLD;
                    r_d.cs = '0;
                    r_d.wr = 1'b0;
                end else begin
                    r_d.scnt = r_q.scnt + 1'b1;
                end
            end
            ST_HOLD: begin
                r_d.st = ST_FETCH;
                if (!r_q.bsel) begin
                    r_d.bsel = 1'b1;
                end else begin
                    r_d.bsel = 1'b0;
                    if (r_q.row == ROW_W'(NUM_ROWS - 1)) begin
                        r_d.row   = '0;
                        r_d.st    = ST_DWELL;
                        r_d.cmp   = CMP_W'(PLANE_CMP[r_q.plane]);
                        r_d.plane = (r_q.plane == PLANE_W'(NUM_PLANES - 1))
                                    ? '0 : r_q.plane + 1'b1;
                    end else begin
                        r_d.row = r_q.row + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_DWELL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.cmp <= CMP_W'(FIRST_CMP);
        end else begin
            r_q <= r_d;
        end
    end

    assign row_addr_o = r_q.addr;
    assign data_o     = rd_data;
    assign wr_en_o    = r_q.wr;
    assign chip_sel_o = r_q.cs;
    assign busy_o     = (r_q.st != ST_DWELL);
    assign sop_o      = r_q.sop;
endmodule

// File: rtl/plane_scan_refresh_chk.sv
module plane_scan_refresh_chk #(
    parameter int BUS_AW = 4,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_ready_o,
    input logic [BUS_AW-1:0] row_addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic              wr_en_o,
    input logic [3:0]        chip_sel_o,
    input logic              busy_o,
    input logic              sop_o
);
    AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(chip_sel_o)); // R3
    AST_ADDR_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o |-> (row_addr_o[BUS_AW-1] == 1'b0)); // R3
    AST_WR_PAIRS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_o == ($countones(chip_sel_o) == 1)); // R5
    AST_SETUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wr_en_o) |-> ($stable(row_addr_o) && $stable(data_o))); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wr_en_o) |-> ($stable(row_addr_o) && $stable(data_o))); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (chip_sel_o == 4'b0000)); // R8
    AST_SOP_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sop_o |-> (busy_o && !$past(busy_o))); // R9
    AST_START_HAS_SOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> sop_o); // R9
    AST_HOST_FREE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> host_ready_o); // R10
endmodule

bind plane_scan_refresh plane_scan_refresh_chk #(.BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/plane_scan_refresh_test.sv
`timescale 1ns/1ps
module plane_scan_refresh_test;
    localparam int PRE = 64, SC = 2, WR_CYC = SC + 3, NWR = 32, NLOC = 96, FIRST = 20;
    localparam int CMPV [3] = '{3, 4, 22};
    // {write index in pass, expected chip select, expected row address}
    localparam logic [12:0] VEC [8] = '{
        {5'd0,  4'b1000, 4'd0}, {5'd1,  4'b0100, 4'd0},
        {5'd14, 4'b1000, 4'd7}, {5'd15, 4'b0100, 4'd7},
        {5'd16, 4'b0001, 4'd0}, {5'd17, 4'b0010, 4'd0},
        {5'd30, 4'b0001, 4'd7}, {5'd31, 4'b0010, 4'd7}};

    logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic host_ready, wr_en, busy, sop;
    logic [3:0] row_addr, chip_sel;
    logic [7:0] data;

    always #2 clk = ~clk;

    plane_scan_refresh #(.STROBE_CYCLES(SC), .PRESCALE(PRE)) uut (
        .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
        .host_wdata_i(host_wdata), .host_ready_o(host_ready), .row_addr_o(row_addr),
        .data_o(data), .wr_en_o(wr_en), .chip_sel_o(chip_sel), .busy_o(busy), .sop_o(sop));

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [NLOC];
    logic [7:0] snap [NLOC];

    logic [3:0] lg_cs [160];
    logic [3:0] lg_addr [160];
    logic [7:0] lg_data [160];
    int dw_log [8];
    int bz_log [8];
    int nlog, ndw, nbz, low_cnt, bz_cnt, nsop, sop_err, stab_err, width_err, slen, nblock, ready_err;
    logic prev_wr, prev_busy;
    logic [3:0] prev_addr;
    logic [7:0] prev_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            nlog = 0; ndw = 0; nbz = 0; low_cnt = 0; bz_cnt = 0; nsop = 0; sop_err = 0;
            stab_err = 0; width_err = 0; slen = 0; nblock = 0; ready_err = 0;
            prev_wr = 1'b0; prev_busy = 1'b0; prev_addr = '0; prev_data = '0;
        end else begin
            if (wr_en && !prev_wr) begin
                if (nlog < 160) begin
                    lg_cs[nlog] = chip_sel; lg_addr[nlog] = row_addr; lg_data[nlog] = data;
                end
                nlog++;
                if (row_addr != prev_addr || data != prev_data) stab_err++;
                slen = 1;
            end else if (wr_en) begin
                slen++;
            end else if (prev_wr) begin
                if (slen != SC) width_err++;
                if (row_addr != prev_addr || data != prev_data) stab_err++;
            end
            if (!busy) low_cnt++;
            if (busy && !prev_busy) begin
                if (ndw < 8) dw_log[ndw] = low_cnt;
                ndw++; low_cnt = 0; bz_cnt = 0;
                if (!sop) sop_err++;
            end
            if (busy) bz_cnt++;
            if (!busy && prev_busy) begin
                if (nbz < 8) bz_log[nbz] = bz_cnt;
                nbz++;
            end
            if (sop) begin
                nsop++;
                if (!(busy && !prev_busy)) sop_err++;
            end
            if (!host_ready) begin
                if (busy) nblock++; else ready_err++;
            end
            prev_wr = wr_en; prev_busy = busy; prev_addr = row_addr; prev_data = data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic host_wr(input int idx, input logic [7:0] val);
        @(negedge clk);
        host_we = 1'b1; host_addr = 7'(idx); host_wdata = val;
        while (!host_ready) @(negedge clk);
        @(posedge clk);
        #1 host_we = 1'b0;
        model[idx] = val;
    endtask

    function automatic logic [7:0] pat(input int p, input int r, input int b);
        return 8'((p * 71 + r * 13 + b * 5 + 9) & 255);
    endfunction

    function automatic logic [3:0] exp_cs(input int r, input int b);
        if (r < 8) return b ? 4'b0100 : 4'b1000;
        return b ? 4'b0010 : 4'b0001;
    endfunction

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int bad;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R1: idle outputs during reset
        chk(!busy && !wr_en && chip_sel == 0 && !sop, "R1 reset outputs idle",
            {busy, wr_en, sop, chip_sel}, 0);
        chk(host_ready, "R1 host ready in reset", host_ready, 1);
        @(posedge clk); #1 rst_n = 1'b1;

        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 16; r++)
                for (int b = 0; b < 2; b++) host_wr(p * 32 + r * 2 + b, pat(p, r, b));
        chk(ndw == 0 && nlog == 0, "R1 still idle after store fill", ndw, 0);

        while (nlog < 40) @(negedge clk);
        for (int i = 0; i < NLOC; i++) snap[i] = model[i];
        host_wr(2 * 32 + 5 * 2 + 1, 8'hC3);   // plane 2 row 5 byte 1, before its pass
        host_wr(0, 8'h3C);                    // plane 0 row 0 byte 0, for the next pass

        while (nlog < 128) @(negedge clk);
        repeat (2) @(negedge clk);

        chk(dw_log[0] == (FIRST + 1) * PRE, "R1 first idle length", dw_log[0], (FIRST + 1) * PRE);
        for (int k = 1; k < 4; k++)
            chk(dw_log[k] == (CMPV[k - 1] + 1) * PRE, "R6 idle length after plane",
                dw_log[k], (CMPV[k - 1] + 1) * PRE);
        for (int k = 0; k < 3; k++)
            chk(bz_log[k] == NWR * WR_CYC, "R8 busy length per pass", bz_log[k], NWR * WR_CYC);

        // table walk: routing and address at the half boundaries, every pass
        for (int v = 0; v < 8; v++)
            for (int k = 0; k < 4; k++) begin
                int j;
                j = k * NWR + int'(VEC[v][12:8]);
                chk(lg_cs[j] == VEC[v][7:4], "R3 chip select", lg_cs[j], VEC[v][7:4]);
                chk(lg_addr[j] == VEC[v][3:0], "R3 row address", lg_addr[j], VEC[v][3:0]);
            end

        for (int k = 0; k < 4; k++) begin
            bad = 0;
            for (int w = 0; w < NWR; w++) begin
                int j, r, b, p;
                logic [7:0] ed;
                j = k * NWR + w; r = w / 2; b = w % 2; p = k % 3;
                ed = (k < 2) ? snap[p * 32 + r * 2 + b] : model[p * 32 + r * 2 + b];
                if (lg_cs[j] != exp_cs(r, b) || lg_addr[j] != 4'(r % 8) || lg_data[j] != ed) bad++;
            end
            chk(bad == 0, "R2 R4 R7 pass order and data", bad, 0);
        end
        chk(lg_data[2 * NWR + 11] == 8'hC3, "R10 mid-pass host byte sent", lg_data[2 * NWR + 11], 8'hC3);
        chk(lg_data[3 * NWR] == 8'h3C, "R10 host byte on next plane 0 pass", lg_data[3 * NWR], 8'h3C);
        chk(stab_err == 0, "R5 address and data stable around strobe", stab_err, 0);
        chk(width_err == 0, "R5 strobe width", width_err, 0);
        chk(sop_err == 0 && nsop == 4, "R9 start pulse per pass", nsop, 4);
        chk(nblock > 0 && ready_err == 0, "R10 host stalled only by scanner", ready_err, 0);

        // reset in the middle of a pass
        while (nlog < 140) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !wr_en && chip_sel == 0 && !sop, "R1 mid-pass reset idles outputs",
            {busy, wr_en, sop, chip_sel}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        while (nlog < 2) @(negedge clk);
        chk(dw_log[0] == (FIRST + 1) * PRE, "R1 first idle after second reset",
            dw_log[0], (FIRST + 1) * PRE);
        chk(lg_data[0] == model[0] && lg_cs[0] == 4'b1000, "R2 restart at plane 0 row 0",
            lg_data[0], model[0]);
        chk(lg_data[1] == model[1] && lg_cs[1] == 4'b0100, "R2 byte 1 follows byte 0",
            lg_data[1], model[1]);
        finish_run();
    end
endmodule